// File: doc/BRIEF.md
# Trace Stream Status and Loss Tracker

This block keeps the health state of three trace streams (program counter, data and timing) and packs it, together with a handful of capture indications computed elsewhere, into a single 32-bit read-only status word. For each stream it holds a sticky loss flag, a done flag and a queue-empty flag. A loss flag records that the stream had to emit a gap packet. It is cleared when a new trace session starts, and the block recognises several distinct restart events for this.

The done flag of a stream drops while the stream is capturing. It comes back only when the stream is inactive and no half-built packet is still waiting to be pushed into the stream's queue. The empty flag follows the encoder-to-export queue occupancy and the pending-packet indication. Every field is registered, so the word reflects the inputs sampled at the previous clock edge. The reset input is asserted asynchronously and released synchronously by a two-stage synchronizer inside the block.

Top module: `trace_status_tracker`

## Requirements
- R1: A pulse on gap_i[k] sets the loss flag of stream k (index 0 program counter, 1 data, 2 timing). The flags appear at status bit 29 (program counter), bit 30 (data) and bit 28 (timing).
- R2: A pulse on lost_clr_i[k] clears the loss flag of stream k.
- R3: The program-counter and timing loss flags also clear on a 0-to-1 change of pc_en_i or tim_en_i respectively, compared with the previous cycle.
- R4: The data loss flag also clears when the data group is restarted. The group is the five bits of dsub_en_i plus evt_en_i. A restart is a cycle where the group was all zero in the previous cycle and has at least one bit set in this one.
- R5: A pulse on own_lost_i clears all three loss flags.
- R6: When a set and a clear of a loss flag occur in the same cycle, the flag is 1 afterwards.
- R7: A stream is active when its enable, export_en_i and not trig_halt_i are all true. The data stream's enable is the OR of dsub_en_i. Status bits 3, 4 and 5 (done flags for program counter, data and timing) go to 0 in the cycle after the stream is active. They return to 1 only after a cycle in which the stream is inactive and part_pend_i[k] is 0; otherwise they hold.
- R8: Status bits 0, 1 and 2 (empty flags for program counter, data and timing) equal the registered value of (occupancy of that stream's queue is 0 AND part_pend_i[k] is 0).
- R9: The status word reflects the registered inputs at fixed positions: bit 6 rd_sb_empty_i, bit 16 pc_cap_i, bit 17 tim_cap_i, bits 22:18 dcap_i, bits 24:23 ecap_i, bits 26:25 plf_i, bit 27 secure_i. Bits 15:7 and bit 31 read 0.
- R10: While reset is applied, the status word is 0x0600007F. This means the empty and done bits and bit 6 are 1, bits 26:25 are 3, and the loss and capture bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gap_i | input | 3 | Per-stream gap-packet pulse (0 PC, 1 data, 2 timing) |
| lost_clr_i | input | 3 | Per-stream write-one-to-clear strobe for the loss flag |
| pc_en_i | input | 1 | Program-counter stream enable level |
| tim_en_i | input | 1 | Timing stream enable level |
| dsub_en_i | input | 5 | Data sub-stream enables (write address, write data, read address, read data, streaming buffer) |
| evt_en_i | input | 1 | Event trace enable, part of the data restart group |
| export_en_i | input | 1 | Global export enable |
| trig_halt_i | input | 1 | Trigger stop level; makes every stream inactive |
| own_lost_i | input | 1 | Ownership-loss pulse |
| part_pend_i | input | 3 | Per-stream partly built packet still pending |
| occ_pc_i | input | OCC_W | Program-counter queue occupancy |
| occ_data_i | input | OCC_W | Data queue occupancy |
| occ_tim_i | input | OCC_W | Timing queue occupancy |
| rd_sb_empty_i | input | 1 | Read scoreboard empty indication |
| plf_i | input | 2 | Pipeline flattener state |
| secure_i | input | 1 | Untraceable code indication |
| pc_cap_i | input | 1 | Program-counter capture active |
| tim_cap_i | input | 1 | Timing capture active |
| dcap_i | input | 5 | Data sub-stream capture active |
| ecap_i | input | 2 | Event capture active |
| status_o | output | 32 | Packed status word |

## Verification
The embedded assertions check cycle-level properties on every cycle. A gap pulse leaves its loss flag set on the next cycle, whatever clear arrives with it. A clear without a gap leaves the flag at 0. An active stream shows done at 0 next cycle. A done flag only rises after an inactive cycle with nothing pending. A non-zero occupancy reads as not empty. Ownership loss without gaps empties all loss bits. Only the bench's scenarios can show the data group restart rule and the enable-edge restarts. The same is true of a done flag that is held through a long drain and the reset word. Field placement is also checked against a reference model under random traffic.

// File: rtl/trc_stat_pkg.sv
package trc_stat_pkg;
  localparam int NSTR     = 3;
  localparam int IDX_PC   = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_TIM  = 2;
  localparam int B_EMPTY  = 0;
  localparam int B_DONE   = 3;
  localparam int B_SB     = 6;
  localparam int B_PCCAP  = 16;
  localparam int B_TCAP   = 17;
  localparam int B_DCAP   = 18;
  localparam int B_ECAP   = 23;
  localparam int B_PLF    = 25;
  localparam int B_SEC    = 27;
  localparam int B_TLOSS  = 28;
  localparam int B_PLOSS  = 29;
  localparam int B_DLOSS  = 30;
  localparam int DSUB_N   = 5;
  localparam int ECAP_W   = 2;
  localparam logic [1:0] PLF_RST = 2'b11;
endpackage

// File: rtl/trc_loss_flag.sv
module trc_loss_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R6
  loss_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R2
  loss_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/trc_stream_done.sv
module trc_stream_done (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic pend_i,
  output logic done_o
);
  logic done_q, done_d, done_en;

  always_comb begin
    done_en = active_i | !pend_i;
    done_d  = !active_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b1;
    else if (done_en) done_q <= done_d;
  end

  assign done_o = done_q;

  // R7
  done_low_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> !done_o);
  // R7
  done_rise_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && (active_i || pend_i)) |=> !done_o);
endmodule

// File: rtl/trc_queue_empty.sv
module trc_queue_empty #(
  parameter int OCC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ_i,
  input  logic             pend_i,
  output logic             empty_o
);
  logic empty_q, empty_d;

  always_comb empty_d = (occ_i == '0) && !pend_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b1;
    else        empty_q <= empty_d;
  end

  assign empty_o = empty_q;

  // R8
  occ_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_i != '0) |=> !empty_o);
endmodule

// File: rtl/trace_status_tracker.sv
module trace_status_tracker
  import trc_stat_pkg::*;
#(
  parameter int OCC_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSTR-1:0]     gap_i,
  input  logic [NSTR-1:0]     lost_clr_i,
  input  logic                pc_en_i,
  input  logic                tim_en_i,
  input  logic [DSUB_N-1:0]   dsub_en_i,
  input  logic                evt_en_i,
  input  logic                export_en_i,
  input  logic                trig_halt_i,
  input  logic                own_lost_i,
  input  logic [NSTR-1:0]     part_pend_i,
  input  logic [OCC_W-1:0]    occ_pc_i,
  input  logic [OCC_W-1:0]    occ_data_i,
  input  logic [OCC_W-1:0]    occ_tim_i,
  input  logic                rd_sb_empty_i,
  input  logic [1:0]          plf_i,
  input  logic                secure_i,
  input  logic                pc_cap_i,
  input  logic                tim_cap_i,
  input  logic [DSUB_N-1:0]   dcap_i,
  input  logic [ECAP_W-1:0]   ecap_i,
  output logic [31:0]         status_o
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // previous enable levels for restart detection
  logic pc_en_q, tim_en_q, grp_any_q, grp_any;
  assign grp_any = (|dsub_en_i) | evt_en_i;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_en_q   <= 1'b0;
      tim_en_q  <= 1'b0;
      grp_any_q <= 1'b0;
    end else begin
      pc_en_q   <= pc_en_i;
      tim_en_q  <= tim_en_i;
      grp_any_q <= grp_any;
    end
  end

  logic [NSTR-1:0] restart, loss_clr, active, str_en, loss, done, empty;
  logic [NSTR-1:0][OCC_W-1:0] occ;

  always_comb begin
    restart[IDX_PC]   = pc_en_i & ~pc_en_q;
    restart[IDX_TIM]  = tim_en_i & ~tim_en_q;
    restart[IDX_DATA] = grp_any & ~grp_any_q;
    str_en[IDX_PC]    = pc_en_i;
    str_en[IDX_TIM]   = tim_en_i;
    str_en[IDX_DATA]  = |dsub_en_i;
    occ[IDX_PC]       = occ_pc_i;
    occ[IDX_DATA]     = occ_data_i;
    occ[IDX_TIM]      = occ_tim_i;
    for (int k = 0; k < NSTR; k++) begin
      loss_clr[k] = lost_clr_i[k] | restart[k] | own_lost_i;
      active[k]   = str_en[k] & export_en_i & ~trig_halt_i;
    end
  end

  for (genvar g = 0; g < NSTR; g++) begin : g_str
    trc_loss_flag u_loss (
      .clk(clk), .rst_n(rst_int_n),
      .set_i(gap_i[g]), .clr_i(loss_clr[g]), .flag_o(loss[g]));
    trc_stream_done u_done (
      .clk(clk), .rst_n(rst_int_n),
      .active_i(active[g]), .pend_i(part_pend_i[g]), .done_o(done[g]));
    trc_queue_empty #(.OCC_W(OCC_W)) u_empty (
      .clk(clk), .rst_n(rst_int_n),
      .occ_i(occ[g]), .pend_i(part_pend_i[g]), .empty_o(empty[g]));
  end

  // reflected indications, registered with their own reset values
  logic              sb_q, sec_q, pccap_q, tcap_q;
  logic [1:0]        plf_q;
  logic [DSUB_N-1:0] dcap_q;
  logic [ECAP_W-1:0] ecap_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sb_q    <= 1'b1;
      plf_q   <= PLF_RST;
      sec_q   <= 1'b0;
      pccap_q <= 1'b0;
      tcap_q  <= 1'b0;
      dcap_q  <= '0;
      ecap_q  <= '0;
    end else begin
      sb_q    <= rd_sb_empty_i;
      plf_q   <= plf_i;
      sec_q   <= secure_i;
      pccap_q <= pc_cap_i;
      tcap_q  <= tim_cap_i;
      dcap_q  <= dcap_i;
      ecap_q  <= ecap_i;
    end
  end

  always_comb begin
    status_o = '0;
    for (int k = 0; k < NSTR; k++) begin
      status_o[B_EMPTY + k] = empty[k];
      status_o[B_DONE + k]  = done[k];
    end
    status_o[B_SB]                 = sb_q;
    status_o[B_PCCAP]              = pccap_q;
    status_o[B_TCAP]               = tcap_q;
    status_o[B_DCAP +: DSUB_N]     = dcap_q;
    status_o[B_ECAP +: ECAP_W]     = ecap_q;
    status_o[B_PLF +: 2]           = plf_q;
    status_o[B_SEC]                = sec_q;
    status_o[B_TLOSS]              = loss[IDX_TIM];
    status_o[B_PLOSS]              = loss[IDX_PC];
    status_o[B_DLOSS]              = loss[IDX_DATA];
  end

  // R5
  own_lost_clears_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (own_lost_i && gap_i == '0) |=> (status_o[B_DLOSS:B_TLOSS] == 3'b000));
  // R1
  gap_sets_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    gap_i[IDX_PC] |=> status_o[B_PLOSS]);
endmodule

// File: tb/test_trace_status_tracker.sv
module test_trace_status_tracker;
  localparam int OW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] gap, lclr, pend;
  logic pc_en, tim_en, evt_en, exp_en, halt, own;
  logic [4:0] dsub, dcap;
  logic [OW-1:0] occ0, occ1, occ2;
  logic sb, sec, pcc, tcc;
  logic [1:0] plf, ecap;
  logic [31:0] status;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  trace_status_tracker #(.OCC_W(OW)) i_trace_status_tracker (
    .clk(clk), .rst_n(rst_n), .gap_i(gap), .lost_clr_i(lclr),
    .pc_en_i(pc_en), .tim_en_i(tim_en), .dsub_en_i(dsub), .evt_en_i(evt_en),
    .export_en_i(exp_en), .trig_halt_i(halt), .own_lost_i(own),
    .part_pend_i(pend), .occ_pc_i(occ0), .occ_data_i(occ1), .occ_tim_i(occ2),
    .rd_sb_empty_i(sb), .plf_i(plf), .secure_i(sec), .pc_cap_i(pcc),
    .tim_cap_i(tcc), .dcap_i(dcap), .ecap_i(ecap), .status_o(status));

  // reference state
  logic [2:0] m_loss, m_done, m_empty;
  logic m_pen, m_ten, m_grp;
  logic [31:0] m_refl;

  function automatic logic nx_loss(logic cur, logic s, logic c);
    return s | (cur & ~c);
  endfunction

  function automatic logic nx_done(logic cur, logic act, logic p);
    if (act) return 1'b0;
    if (!p)  return 1'b1;
    return cur;
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = m_refl;
    w[2:0] = m_empty;
    w[5:3] = m_done;
    w[29] = m_loss[0];
    w[30] = m_loss[1];
    w[28] = m_loss[2];
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic [2:0] restart, act, en;
    logic grp;
    grp = (|dsub) | evt_en;
    restart = {tim_en & ~m_ten, grp & ~m_grp, pc_en & ~m_pen};
    en = {tim_en, |dsub, pc_en};
    for (int k = 0; k < 3; k++) begin
      act[k] = en[k] & exp_en & ~halt;
      m_loss[k] = nx_loss(m_loss[k], gap[k], lclr[k] | restart[k] | own);
      m_done[k] = nx_done(m_done[k], act[k], pend[k]);
    end
    m_empty = {(occ2 == 0) && !pend[2], (occ1 == 0) && !pend[1], (occ0 == 0) && !pend[0]};
    m_pen = pc_en; m_ten = tim_en; m_grp = grp;
    m_refl = '0;
    m_refl[6] = sb; m_refl[16] = pcc; m_refl[17] = tcc;
    m_refl[22:18] = dcap; m_refl[24:23] = ecap; m_refl[26:25] = plf; m_refl[27] = sec;
  endtask

  task automatic step();
    logic [31:0] e;
    @(posedge clk);
    model_update();
    @(negedge clk);
    e = exp_word();
    check("R1 R2 R3 R4 R5 R6 loss flags", {1'b0, status[30:28], 28'h0}, {1'b0, e[30:28], 28'h0});
    check("R7 done flags", {26'h0, status[5:3], 3'h0}, {26'h0, e[5:3], 3'h0});
    check("R8 empty flags", {29'h0, status[2:0]}, {29'h0, e[2:0]});
    check("R9 reflected and reserved", status & 32'h8FFF_FFC0, e & 32'h8FFF_FFC0);
  endtask

  task automatic quiet();
    gap = 0; lclr = 0; pend = 0; pc_en = 0; tim_en = 0; evt_en = 0; exp_en = 0;
    halt = 0; own = 0; dsub = 0; dcap = 0; occ0 = 0; occ1 = 0; occ2 = 0;
    sb = 1; sec = 0; pcc = 0; tcc = 0; plf = 2'b11; ecap = 0;
  endtask

  task automatic randomize_inputs();
    gap  = {($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0};
    lclr = {($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0};
    own  = ($urandom % 16) == 0;
    if (($urandom % 6) == 0) pc_en = ~pc_en;
    if (($urandom % 6) == 0) tim_en = ~tim_en;
    if (($urandom % 5) == 0) dsub = (($urandom % 2) == 0) ? 5'd0 : 5'($urandom);
    if (($urandom % 7) == 0) evt_en = ~evt_en;
    exp_en = ($urandom % 5) != 0;
    halt = ($urandom % 9) == 0;
    pend = 3'($urandom) & 3'($urandom);
    occ0 = (($urandom % 2) == 0) ? '0 : OW'($urandom);
    occ1 = (($urandom % 2) == 0) ? '0 : OW'($urandom);
    occ2 = (($urandom % 2) == 0) ? '0 : OW'($urandom);
    sb = 1'($urandom); sec = 1'($urandom); pcc = 1'($urandom); tcc = 1'($urandom);
    plf = 2'($urandom); ecap = 2'($urandom); dcap = 5'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    quiet();
    rst_n = 1'b0;
    m_loss = 0; m_done = 3'b111; m_empty = 3'b111;
    m_pen = 0; m_ten = 0; m_grp = 0;
    m_refl = 32'h0600_0040;
    repeat (3) @(negedge clk);
    // R10 reset word
    check("R10 reset word", status, 32'h0600_007F);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 word after release with quiet inputs", status, 32'h0600_007F);

    // R6: set and clear together on PC flag
    gap = 3'b001; lclr = 3'b001; step();
    check("R6 set beats clear", {31'h0, status[29]}, 32'h1);
    gap = 0; lclr = 3'b001; step();
    check("R2 w1c clears pc loss", {31'h0, status[29]}, 32'h0);

    // R3: timing enable rising edge clears timing flag
    gap = 3'b100; lclr = 0; step();
    gap = 0; tim_en = 1; step();
    check("R3 timing enable rise clears", {31'h0, status[28]}, 32'h0);
    tim_en = 0;

    // R4: data group restart
    dsub = 5'b00001; step();
    gap = 3'b010; step();
    gap = 0; dsub = 5'b00010; step();
    check("R4 flag kept while group stays on", {31'h0, status[30]}, 32'h1);
    dsub = 0; evt_en = 0; step();
    check("R4 flag kept while group off", {31'h0, status[30]}, 32'h1);
    dsub = 5'b00100; step();
    check("R4 group restart clears data loss", {31'h0, status[30]}, 32'h0);
    dsub = 0;

    // R7: done waits for drain
    pc_en = 1; exp_en = 1; step();
    check("R7 done low while active", {31'h0, status[3]}, 32'h0);
    pc_en = 0; pend = 3'b001; step();
    repeat (3) step();
    check("R7 done held while partial pending", {31'h0, status[3]}, 32'h0);
    check("R8 not empty while partial pending", {31'h0, status[0]}, 32'h0);
    pend = 0; step();
    check("R7 done after drain", {31'h0, status[3]}, 32'h1);

    // R5: ownership loss clears all flags
    gap = 3'b111; step();
    gap = 0; own = 1; step();
    check("R5 own loss clears all", {29'h0, status[30:28]}, 32'h0);
    own = 0;

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule